// File: doc/BRIEF.md
# Memory Barrier Commit Tracker

This block sits where a processor sends requests off chip. It decides when a memory barrier may retire. Each request carries a small id. The block keeps one slot per id, and each slot records two things: whether the request's commit is still owed, and whether its data is still owed. Commit events and data-return events arrive on separate pulse inputs. They are independent of each other, and for the same request either one may come first.

The outstanding count is the number of slots still waiting for a commit. A barrier is requested by holding a level input high. While the request is pending, new issues are stalled by dropping the ready output. Once the count is zero, a one-cycle done pulse is produced, and the requester then releases the request. Only commits hold a barrier back. Read data that is still in flight does not, so reads issued after the barrier can go out without waiting for earlier data returns.

A slot can take a new request only after both its commit and its data have come back. Any protocol violation sets a sticky error flag. The violations are:
- a commit for an id with no commit owed,
- data for an id with no data owed,
- an issue to an id that is still busy.

Top module: `mbar_commit_tracker`

## Requirements
- R1: During and right after reset, `outstanding` is 0, `issue_ready` is 1, `bar_done` is 0 and `err_flag` is 0.
- R2: An issue accepted on a clock edge (`issue_valid` and `issue_ready` high, and the id's slot is neither awaiting commit nor awaiting data) raises `outstanding` by one after that edge.
- R3: A commit for an id whose commit is owed lowers `outstanding` by one after the edge. A data return never changes `outstanding`, whether it comes before or after the commit.
- R4: An accepted issue and a valid commit on the same edge, for different ids, leave `outstanding` unchanged.
- R5: `bar_done` is high for exactly one cycle per barrier request. It rises only on the edge after one at which `outstanding` was 0, so it waits for commits but not for data returns.
- R6: If `bar_req` is first sampled high while `outstanding` is 0, `bar_done` is high in the very next cycle.
- R7: `issue_ready` is 0 whenever `bar_req` is 1, and stays 0 from the barrier until `bar_req` is sampled low after `bar_done`. An `issue_valid` pulse while `issue_ready` is 0 does not change `outstanding`.
- R8: A commit for an id whose commit is not owed sets `err_flag` after the edge and leaves `outstanding` unchanged.
- R9: Each of the following sets `err_flag` and is otherwise ignored: an issue to an id still awaiting its commit or its data, or a data return for an id not awaiting data. Once an id has received both its commit and its data, it can be issued again without error.
- R10: Once set, `err_flag` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | One-cycle pulse: a new off-chip request |
| issue_id | input | ID_W | Id of the new request |
| issue_ready | output | 1 | Issues are accepted only while this is 1 |
| commit_valid | input | 1 | One-cycle pulse: a commit event |
| commit_id | input | ID_W | Id the commit belongs to |
| data_valid | input | 1 | One-cycle pulse: a data return |
| data_id | input | ID_W | Id the data belongs to |
| bar_req | input | 1 | Barrier request, held high until `bar_done` is seen |
| bar_done | output | 1 | One-cycle pulse: the barrier may retire |
| outstanding | output | CNT_W | Number of requests still awaiting a commit |
| err_flag | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that `bar_req` is held high until `bar_done` has been seen and is then released. The count properties rely on the event inputs being single-cycle pulses, sampled on every edge. The stimulus drives every pulse for exactly one cycle. It drops `bar_req` only after it has observed the done pulse. It provokes error cases on purpose only inside sections that end in a reset. This keeps the sticky flag's later checks meaningful.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int DEF_ID_W = 3;

    typedef enum logic [1:0] {
        BAR_IDLE = 2'd0,
        BAR_WAIT = 2'd1,
        BAR_DONE = 2'd2
    } bar_state_e;

    function automatic int unsigned slots_for(int unsigned id_w);
        return 1 << id_w;
    endfunction

    function automatic int unsigned cnt_width(int unsigned id_w);
        return $clog2((1 << id_w) + 1);
    endfunction

endpackage

// File: rtl/mbt_slot_table.sv
module mbt_slot_table #(
    parameter int ID_W = mbt_pkg::DEF_ID_W,
    localparam int SLOTS = mbt_pkg::slots_for(ID_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_v,
    input  logic [ID_W-1:0]  iss_id,
    input  logic             cmt_v,
    input  logic [ID_W-1:0]  cmt_id,
    input  logic             dat_v,
    input  logic [ID_W-1:0]  dat_id,
    output logic             inc,
    output logic             dec,
    output logic             err,
    output logic [SLOTS-1:0] pend_cmt
);

    logic [SLOTS-1:0] cmt_q, cmt_d;
    logic [SLOTS-1:0] dat_q, dat_d;
    logic             iss_busy, bad_cmt, bad_dat, dat_ok;

    assign iss_busy = cmt_q[iss_id] | dat_q[iss_id];
    assign inc      = iss_v && !iss_busy;
    assign dec      = cmt_v && cmt_q[cmt_id];
    assign bad_cmt  = cmt_v && !cmt_q[cmt_id];
    assign dat_ok   = dat_v && dat_q[dat_id];
    assign bad_dat  = dat_v && !dat_q[dat_id];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic take;
        assign take     = inc && (iss_id == ID_W'(i));
        assign cmt_d[i] = take | (cmt_q[i] & ~(dec && (cmt_id == ID_W'(i))));
        assign dat_d[i] = take | (dat_q[i] & ~(dat_ok && (dat_id == ID_W'(i))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmt_q <= '0;
            dat_q <= '0;
            err   <= 1'b0;
        end else begin
            cmt_q <= cmt_d;
            dat_q <= dat_d;
            err   <= err | (iss_v && iss_busy) | bad_cmt | bad_dat;
        end
    end

    assign pend_cmt = cmt_q;

    // R10: the error flag never clears outside reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9: an issue to a busy slot flags an error and leaves the slot state alone
    p_busy_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_v && iss_busy && !cmt_v && !dat_v) |=> (err && $stable(cmt_q) && $stable(dat_q)));

endmodule

// File: rtl/mbt_counter.sv
module mbt_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign zero = (cnt == '0);

    // R3: a decrement never wraps below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |-> (cnt != '0));

    // R4: a simultaneous increment and decrement hold the count
    p_inc_dec_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/mbt_barrier_fsm.sv
module mbt_barrier_fsm
    import mbt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bar_req,
    input  logic cnt_zero,
    output logic bar_done,
    output logic issue_ok
);

    bar_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BAR_IDLE;
            bar_done <= 1'b0;
        end else begin
            bar_done <= 1'b0;
            unique case (state)
                BAR_IDLE: begin
                    if (bar_req && cnt_zero) begin
                        state    <= BAR_DONE;
                        bar_done <= 1'b1;
                    end else if (bar_req) begin
                        state <= BAR_WAIT;
                    end
                end
                BAR_WAIT: begin
                    if (cnt_zero) begin
                        state    <= BAR_DONE;
                        bar_done <= 1'b1;
                    end
                end
                BAR_DONE: begin
                    if (!bar_req) state <= BAR_IDLE;
                end
                default: state <= BAR_IDLE;
            endcase
        end
    end

    assign issue_ok = (state == BAR_IDLE) && !bar_req;

    // R5: done rises only after a cycle with nothing outstanding
    p_done_needs_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(bar_done) |-> $past(cnt_zero));

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        bar_done |=> !bar_done);

    // R6: a request seen from idle with zero count completes on the next edge
    p_fast_done_r6: assert property (@(posedge clk) disable iff (rst)
        (state == BAR_IDLE && bar_req && cnt_zero) |=> bar_done);

endmodule

// File: rtl/mbar_commit_tracker.sv
module mbar_commit_tracker #(
    parameter int ID_W = mbt_pkg::DEF_ID_W,
    localparam int SLOTS = mbt_pkg::slots_for(ID_W),
    localparam int CNT_W = mbt_pkg::cnt_width(ID_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [ID_W-1:0]  issue_id,
    output logic             issue_ready,
    input  logic             commit_valid,
    input  logic [ID_W-1:0]  commit_id,
    input  logic             data_valid,
    input  logic [ID_W-1:0]  data_id,
    input  logic             bar_req,
    output logic             bar_done,
    output logic [CNT_W-1:0] outstanding,
    output logic             err_flag
);

    logic             iss_fire, inc, dec, cnt_zero;
    logic [SLOTS-1:0] pend_cmt;

    assign iss_fire = issue_valid && issue_ready;

    mbt_slot_table #(.ID_W(ID_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .iss_v    (iss_fire),
        .iss_id   (issue_id),
        .cmt_v    (commit_valid),
        .cmt_id   (commit_id),
        .dat_v    (data_valid),
        .dat_id   (data_id),
        .inc      (inc),
        .dec      (dec),
        .err      (err_flag),
        .pend_cmt (pend_cmt)
    );

    mbt_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .inc  (inc),
        .dec  (dec),
        .cnt  (outstanding),
        .zero (cnt_zero)
    );

    mbt_barrier_fsm u_bar (
        .clk      (clk),
        .rst      (rst),
        .bar_req  (bar_req),
        .cnt_zero (cnt_zero),
        .bar_done (bar_done),
        .issue_ok (issue_ready)
    );

    // R2: the counter always equals the number of slots owing a commit
    p_count_match_r2: assert property (@(posedge clk) disable iff (rst)
        outstanding == CNT_W'($countones(pend_cmt)));

    // R8: a commit with nothing owed raises the error flag
    p_bad_commit_r8: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && !pend_cmt[commit_id]) |=> err_flag);

    // R7: while a barrier is requested the count can never grow
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        bar_req |=> (outstanding <= $past(outstanding)));

endmodule

// File: tb/sim_mbar_commit_tracker.sv
module sim_mbar_commit_tracker;

    localparam int ID_W  = 3;
    localparam int CNT_W = mbt_pkg::cnt_width(ID_W);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             issue_valid = 1'b0;
    logic [ID_W-1:0]  issue_id = '0;
    logic             issue_ready;
    logic             commit_valid = 1'b0;
    logic [ID_W-1:0]  commit_id = '0;
    logic             data_valid = 1'b0;
    logic [ID_W-1:0]  data_id = '0;
    logic             bar_req = 1'b0;
    logic             bar_done;
    logic [CNT_W-1:0] outstanding;
    logic             err_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    mbar_commit_tracker #(.ID_W(ID_W)) u0 (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_id(issue_id), .issue_ready(issue_ready),
        .commit_valid(commit_valid), .commit_id(commit_id),
        .data_valid(data_valid), .data_id(data_id),
        .bar_req(bar_req), .bar_done(bar_done),
        .outstanding(outstanding), .err_flag(err_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic pulse(input logic iv, input int iid, input logic cv, input int cid,
                         input logic dv, input int did);
        issue_valid  = iv;  issue_id  = ID_W'(iid);
        commit_valid = cv;  commit_id = ID_W'(cid);
        data_valid   = dv;  data_id   = ID_W'(did);
        tick();
        issue_valid = 1'b0; commit_valid = 1'b0; data_valid = 1'b0;
    endtask

    // wait for the done pulse seen by the monitor, then release the request
    task automatic finish_barrier(input string req);
        int n = 0;
        while (!bar_done && n < 50) begin
            tick();
            n++;
        end
        chk(req, int'(bar_done), 1);
        bar_req = 1'b0;
        tick();
        chk("R7 ready back after release", int'(issue_ready), 1);
    endtask

    // monitor: scoreboard of expected done cycles
    always @(negedge clk) begin
        if (!rst && bar_done) begin
            checks++;
            if (done_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected bar_done: actual cycle %0d expected none", cyc);
            end else begin
                int exp_c;
                exp_c = done_q.pop_front();
                if (exp_c != cyc) begin
                    errors++;
                    $display("FAIL R5/R6 bar_done timing: actual cycle %0d expected %0d", cyc, exp_c);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        tick();
        chk("R1 count in reset", int'(outstanding), 0);
        chk("R1 ready in reset", int'(issue_ready), 1);
        chk("R1 done in reset", int'(bar_done), 0);
        chk("R1 err in reset", int'(err_flag), 0);
        do_reset();
        chk("R1 count after reset", int'(outstanding), 0);
        chk("R1 err after reset", int'(err_flag), 0);

        // R2 issues
        pulse(1, 0, 0, 0, 0, 0);
        chk("R2 count after issue 0", int'(outstanding), 1);
        pulse(1, 1, 0, 0, 0, 0);
        pulse(1, 2, 0, 0, 0, 0);
        chk("R2 count after three issues", int'(outstanding), 3);

        // R3 data return first does not change count
        pulse(0, 0, 0, 0, 1, 1);
        chk("R3 data leaves count", int'(outstanding), 3);

        // R4 issue 3 with commit 0 together
        pulse(1, 3, 1, 0, 0, 0);
        chk("R4 issue+commit hold", int'(outstanding), 3);

        // R3 commit after its data
        pulse(0, 0, 1, 1, 0, 0);
        chk("R3 commit decrements", int'(outstanding), 2);
        chk("R9 no error so far", int'(err_flag), 0);

        // R7 / R5 barrier waiting on commits of 2 and 3, data 0,2,3 still owed
        bar_req = 1'b1;
        #1;
        chk("R7 ready low under barrier", int'(issue_ready), 0);
        pulse(1, 5, 0, 0, 0, 0);
        chk("R7 stalled issue ignored", int'(outstanding), 2);
        pulse(0, 0, 1, 2, 0, 0);
        chk("R5 no done with one owed", int'(bar_done), 0);
        chk("R7 ready still low", int'(issue_ready), 0);
        done_q.push_back(cyc + 2);
        pulse(0, 0, 1, 3, 0, 0);
        chk("R3 count reaches zero", int'(outstanding), 0);
        finish_barrier("R5 done with data in flight");

        // R6 immediate barrier
        bar_req = 1'b1;
        done_q.push_back(cyc + 1);
        tick();
        chk("R6 done next cycle", int'(bar_done), 1);
        finish_barrier("R6 done seen");

        // R9 late data returns are accepted without error
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 0, 1, 2);
        chk("R3 late data count", int'(outstanding), 0);
        chk("R9 late data no error", int'(err_flag), 0);

        // R9 reuse after both returned
        pulse(1, 1, 0, 0, 0, 0);
        chk("R9 reuse id 1 count", int'(outstanding), 1);
        chk("R9 reuse id 1 no error", int'(err_flag), 0);

        // R8 commit for id 6 which owes nothing
        pulse(0, 0, 1, 6, 0, 0);
        chk("R8 error raised", int'(err_flag), 1);
        chk("R8 count unchanged", int'(outstanding), 1);
        tick();
        tick();
        chk("R10 error sticky", int'(err_flag), 1);
        do_reset();
        chk("R10 error cleared by reset", int'(err_flag), 0);
        chk("R1 count cleared by reset", int'(outstanding), 0);

        // R9 issue to id awaiting data only
        pulse(1, 4, 0, 0, 0, 0);
        pulse(0, 0, 1, 4, 0, 0);
        chk("R9 commit ok", int'(err_flag), 0);
        pulse(1, 4, 0, 0, 0, 0);
        chk("R9 busy issue error", int'(err_flag), 1);
        chk("R9 busy issue ignored", int'(outstanding), 0);
        do_reset();

        // R9 issue to id awaiting commit
        pulse(1, 7, 0, 0, 0, 0);
        pulse(1, 7, 0, 0, 0, 0);
        chk("R9 double issue error", int'(err_flag), 1);
        chk("R9 double issue count", int'(outstanding), 1);
        do_reset();

        // R9 data for id never issued
        pulse(0, 0, 0, 0, 1, 5);
        chk("R9 stray data error", int'(err_flag), 1);
        chk("R3 stray data count", int'(outstanding), 0);
        do_reset();

        tick();
        chk("R5 no pending done", done_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule